// File: doc/BRIEF.md
# Region-Decoded Data Memory

This block is a unified data memory whose address space is carved into three regions by its two highest address bits. The lower half of the space is general read/write storage. The next quarter is a read/write frame buffer for a display. The top quarter holds a single read-only word that mirrors a 16-bit key code supplied from outside. The block decodes each address, gives the write strobe only to the region that is hit, and returns that region's word on the read port.

Reads are combinational from the address. Writes take effect on the rising clock edge while `load` is high. The `load` pin never shapes the read data directly: the output is a function of the address, the stored words and the key code only. No region is built from another region's storage. The word store is one sized array and the frame buffer is a second array half as deep.

`ADDR_W` sets the address width. A full-size build uses 15, which gives 16K words of storage and an 8K-word frame buffer. The default of 12 keeps elaboration small. The read and write paths are plain ports, because every access completes in a single cycle.

Top module: `mmap_data_mem`

## Requirements
- R1: With `addr[ADDR_W-1]`=0, the read port returns the word-store entry indexed by `addr[ADDR_W-2:0]`. The value of `addr[ADDR_W-2]` plays no part in choosing this region.
- R2: With `addr[ADDR_W-1:ADDR_W-2]`=2'b10, the read port returns the frame-buffer entry indexed by `addr[ADDR_W-3:0]`.
- R3: With `addr[ADDR_W-1:ADDR_W-2]`=2'b11 and `addr[ADDR_W-3:0]`=0, the read port returns `key_code` in the same cycle.
- R4: With `addr[ADDR_W-1:ADDR_W-2]`=2'b11 and `addr[ADDR_W-3:0]` nonzero, the read port returns zero.
- R5: A rising edge with `load`=1 stores `wdata` at the addressed word-store or frame-buffer entry. The next cycle reads that value back at the same address.
- R6: While the clock is held, changing `load` or `wdata` leaves `rdata` unchanged.
- R7: A write aimed at the top quarter changes no stored word in either writable region.
- R8: A write changes only the selected region. A word-store write leaves the frame buffer unchanged at the same low index, and a frame-buffer write leaves the word store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| addr | input | ADDR_W | Word address, region in top two bits |
| wdata | input | DATA_W | Word to store |
| load | input | 1 | Write strobe for the addressed word |
| key_code | input | DATA_W | External key code, readable at the key address |
| rdata | output | DATA_W | Word read from the addressed region |

## Verification
The bench first fills both writable regions completely. Random mixes of reads and writes are then spread over all four address quarters, so that both word-store quarters are shown to act as one region and each quarter is shown to be kept apart from the others. Directed cases write at matching low indices in the two writable regions, which exposes any aliasing between them. They also write into the key quarter and then re-read neighbouring stored words, which shows that such writes are dropped. A few cases toggle `load` and `wdata` in mid-cycle to confirm that the read path has no route from the strobe. The key hole addresses are read with a nonzero key code, which separates a correct zero fill from a decoder that ignores the low bits.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  typedef enum logic [1:0] {
    REG_STORE = 2'd0,
    REG_FRAME = 2'd1,
    REG_KEY   = 2'd2,
    REG_HOLE  = 2'd3
  } region_e;
endpackage

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              load,
  output region_e           region,
  output logic              store_we,
  output logic              frame_we
);
  localparam int LOW_W = ADDR_W - 2;

  logic [1:0]     top_bits;
  logic [LOW_W-1:0] low_bits;

  assign top_bits = addr[ADDR_W-1:ADDR_W-2];
  assign low_bits = addr[LOW_W-1:0];

  always_comb begin
    if (!top_bits[1])          region = REG_STORE;
    else if (!top_bits[0])     region = REG_FRAME;
    else if (low_bits == '0)   region = REG_KEY;
    else                       region = REG_HOLE;
  end

  assign store_we = load && (region == REG_STORE);
  assign frame_we = load && (region == REG_FRAME);
endmodule

// File: rtl/mmap_word_store.sv
module mmap_word_store #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] idx,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/mmap_data_mem.sv
module mmap_data_mem
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  input  logic [DATA_W-1:0] key_code,
  output logic [DATA_W-1:0] rdata
);
  localparam int STORE_AW = ADDR_W - 1;
  localparam int FRAME_AW = ADDR_W - 2;

  region_e           region;
  logic              ram_we;
  logic              scr_we;
  logic [DATA_W-1:0] store_q;
  logic [DATA_W-1:0] frame_q;

  mmap_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .load     (load),
    .region   (region),
    .store_we (ram_we),
    .frame_we (scr_we)
  );

  mmap_word_store #(.AW(STORE_AW), .DW(DATA_W)) u_store (
    .clk   (clk),
    .idx   (addr[STORE_AW-1:0]),
    .we    (ram_we),
    .wdata (wdata),
    .rdata (store_q)
  );

  mmap_word_store #(.AW(FRAME_AW), .DW(DATA_W)) u_frame (
    .clk   (clk),
    .idx   (addr[FRAME_AW-1:0]),
    .we    (scr_we),
    .wdata (wdata),
    .rdata (frame_q)
  );

  always_comb begin
    unique case (region)
      REG_STORE: rdata = store_q;
      REG_FRAME: rdata = frame_q;
      REG_KEY:   rdata = key_code;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/mmap_data_mem_chk.sv
module mmap_data_mem_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              load,
  input logic [DATA_W-1:0] key_code,
  input logic [DATA_W-1:0] rdata,
  input logic              ram_we,
  input logic              scr_we
);
  localparam int TOP = ADDR_W - 1;
  localparam int LOW_W = ADDR_W - 2;

  logic [1:0] age = 2'd0;
  logic       armed;
  always_ff @(posedge clk) begin
    if (age != 2'd2) age <= age + 2'd1;
  end
  assign armed = (age == 2'd2);

  logic key_quarter, key_exact;
  assign key_quarter = (addr[TOP:TOP-1] == 2'b11);
  assign key_exact   = key_quarter && (addr[LOW_W-1:0] == '0);

  assert_key_read_R3: assert property (@(posedge clk) disable iff (!armed)
    key_exact |-> (rdata == key_code));

  assert_key_hole_R4: assert property (@(posedge clk) disable iff (!armed)
    (key_quarter && !key_exact) |-> (rdata == '0));

  assert_store_write_R5: assert property (@(posedge clk) disable iff (!armed)
    (load && !addr[TOP]) |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

  assert_frame_write_R5: assert property (@(posedge clk) disable iff (!armed)
    (load && addr[TOP:TOP-1] == 2'b10) |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

  assert_key_nowrite_R7: assert property (@(posedge clk) disable iff (!armed)
    key_quarter |-> (!ram_we && !scr_we));

  assert_steer_store_R8: assert property (@(posedge clk) disable iff (!armed)
    (load && !addr[TOP]) |-> (ram_we && !scr_we));

  assert_steer_frame_R8: assert property (@(posedge clk) disable iff (!armed)
    (load && addr[TOP:TOP-1] == 2'b10) |-> (scr_we && !ram_we));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!armed)
    !load |-> $onehot0({ram_we, scr_we}) && !ram_we && !scr_we);
endmodule

bind mmap_data_mem mmap_data_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .addr     (addr),
  .wdata    (wdata),
  .load     (load),
  .key_code (key_code),
  .rdata    (rdata),
  .ram_we   (ram_we),
  .scr_we   (scr_we)
);

// File: tb/tb_mmap_data_mem.sv
`timescale 1ns/1ps
module tb_mmap_data_mem;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int SD = 1 << (AW - 1);
  localparam int FD = 1 << (AW - 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          load = 1'b0;
  logic [DW-1:0] key_code = '0;
  logic [DW-1:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [DW-1:0] store_m [SD];
  logic [DW-1:0] frame_m [FD];

  always #4 clk = ~clk;

  mmap_data_mem #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .addr(addr), .wdata(wdata), .load(load),
    .key_code(key_code), .rdata(rdata)
  );

  function automatic logic [DW-1:0] model_read(logic [AW-1:0] a, logic [DW-1:0] k);
    if (!a[AW-1])               return store_m[a[AW-2:0]];
    else if (!a[AW-2])          return frame_m[a[AW-3:0]];
    else if (a[AW-3:0] == '0)   return k;
    else                        return '0;
  endfunction

  function automatic string region_tag(logic [AW-1:0] a);
    if (!a[AW-1])             return "R1";
    else if (!a[AW-2])        return "R2";
    else if (a[AW-3:0] == '0) return "R3";
    else                      return "R4";
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [DW-1:0] d);
    if (!a[AW-1])      store_m[a[AW-2:0]] = d;
    else if (!a[AW-2]) frame_m[a[AW-3:0]] = d;
  endtask

  task automatic check(logic [DW-1:0] got, logic [DW-1:0] exp, string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, got, exp);
    end
  endtask

  task automatic op(logic [AW-1:0] a, logic [DW-1:0] d, bit ld, logic [DW-1:0] k,
                    bit chk, string req);
    @(negedge clk);
    addr = a; wdata = d; load = ld; key_code = k;
    #2;
    if (chk) check(rdata, model_read(a, k), req);
    @(posedge clk);
    if (ld) model_write(a, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] ka;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    ka = {2'b11, {(AW-2){1'b0}}};
    // reset phase: load held low, key word visible (R3)
    repeat (4) begin
      @(negedge clk); addr = ka; key_code = 16'hA5C3; load = 1'b0;
      #2 check(rdata, 16'hA5C3, "R3 reset");
    end
    rst = 1'b0;

    // fill both writable regions
    for (int i = 0; i < SD; i++) op(AW'(i), DW'(i * 7 + 3), 1, 0, 0, "");
    for (int i = 0; i < FD; i++) op(AW'(SD + i), DW'(16'hF000 ^ i), 1, 0, 0, "");

    // R1: both store quarters act as one region, bit AW-2 part of index
    op(AW'(12), 0, 0, 0, 1, "R1 low quarter");
    op(AW'(SD/2 + 12), 0, 0, 0, 1, "R1 upper quarter");
    // R2
    op(AW'(SD + 5), 0, 0, 0, 1, "R2 frame read");
    // R3 / R4 with nonzero key
    op(ka, 0, 0, 16'h1234, 1, "R3 key exact");
    op(ka + 1, 0, 0, 16'h1234, 1, "R4 hole low");
    op({AW{1'b1}}, 0, 0, 16'hFFFF, 1, "R4 hole top");
    // R5: write then read back
    op(AW'(33), 16'hBEEF, 1, 0, 1, "R5 pre");
    op(AW'(33), 0, 0, 0, 1, "R5 store readback");
    op(AW'(SD + 33), 16'hCAFE, 1, 0, 1, "R5 pre");
    op(AW'(SD + 33), 0, 0, 0, 1, "R5 frame readback");
    // R8: same low index in both writable regions
    op(AW'(5), 16'h1111, 1, 0, 1, "R8 pre");
    op(AW'(SD + 5), 0, 0, 0, 1, "R8 frame untouched");
    op(AW'(SD + 5), 16'h2222, 1, 0, 1, "R8 pre");
    op(AW'(5), 0, 0, 0, 1, "R8 store untouched");
    // R7: writes into key quarter are dropped
    op(ka, 16'hDEAD, 1, 16'h0042, 1, "R7 pre");
    op(ka + 3, 16'hDEAD, 1, 16'h0042, 1, "R7 pre");
    op(ka, 0, 0, 16'h0042, 1, "R7 key still input");
    op(AW'(0), 0, 0, 0, 1, "R7 store idx0");
    op(AW'(3), 0, 0, 0, 1, "R7 store idx3");
    op(AW'(SD), 0, 0, 0, 1, "R7 frame idx0");
    op(AW'(SD + 3), 0, 0, 0, 1, "R7 frame idx3");
    // R6: mid-cycle toggling of load and wdata
    @(negedge clk);
    addr = AW'(7); load = 1'b0; wdata = 16'h0F0F;
    #1 check(rdata, model_read(addr, key_code), "R6 base");
    load = 1'b1; wdata = 16'h7777;
    #1 check(rdata, model_read(addr, key_code), "R6 load high");
    wdata = 16'h8888;
    #1 check(rdata, model_read(addr, key_code), "R6 wdata change");
    load = 1'b0;
    #0.5 check(rdata, model_read(addr, key_code), "R6 load low");
    @(posedge clk);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d, k;
      bit ld;
      a  = AW'($urandom);
      if ($urandom_range(0, 7) == 0) a = {2'b11, {(AW-2){1'b0}}};
      d  = DW'($urandom);
      k  = DW'($urandom);
      ld = ($urandom_range(0, 2) == 0);
      op(a, d, ld, k, 1, region_tag(a));
    end
    finish_run();
  end
endmodule